// File: doc/BRIEF.md
# Masked Shadow-Latch Bus Writer

This block drives four external 8-bit holding latches that hang off one shared 8-bit data bus. Each latch has its own active-low load line, and the four lines together form a strobe bus. The block keeps an internal copy of what each latch holds, because the latches cannot be read back. A host asks for an update by giving a latch number, a value and a mask. Only the masked bits change. The block folds those bits into the stored copy and drives the full merged byte onto the shared bus. It then pulls the chosen latch's load line low and releases it again. Each of these three steps is held for a fixed settle time.

A second request form sets or clears one bit. The host gives a bit position and a level, and the block turns this into a single-bit masked write. While a transfer is in flight, the host sees busy, and a one-cycle done marks its end. A request that names a latch outside 0..3 is refused with a one-cycle error flag. The four stored copies are visible on an output so that the host can see the state of each latch.

Top module: `latch_bus_writer`

## Requirements
- R1: After reset all four stored copies are 0, bus_data is 0, strobe_n is 4'b1111, and busy, done and err are 0.
- R2: An accepted masked request for latch n makes copy n equal to (old AND NOT mask) OR (value AND mask), visible on shadow_flat[8n+7:8n] in the cycle after acceptance.
- R3: From the cycle after acceptance, bus_data carries the full merged byte of the addressed latch. It holds that value until the next accepted write.
- R4: strobe_n idles at 4'b1111. While latch n is being loaded, strobe_n equals 4'b1111 XOR (1 << n), so only bit n is low.
- R5: After acceptance the data phase lasts DELAY_CYC cycles with strobe_n idle. The load line is then low for exactly DELAY_CYC cycles, and strobe_n stays idle for a further DELAY_CYC cycles.
- R6: busy is high for exactly 3*DELAY_CYC cycles, starting the cycle after acceptance. done is high for one cycle only, in the first cycle that busy is low again.
- R7: A request presented while busy is ignored. It changes no stored copy, does not change bus_data and starts no strobe.
- R8: A request with req_idx of 4 or more gives err = 1 for exactly the next cycle. It leaves busy low and changes no stored copy, no bus_data and no strobe.
- R9: With req_bit = 1, the request acts as a masked write with mask = 1 << req_pos and value = req_level ? 1 << req_pos : 0. req_value and req_mask are ignored.
- R10: An accepted write to latch n leaves the other three stored copies unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_idx | input | 3 | Latch number; values 4..7 are refused |
| req_bit | input | 1 | 1 selects the single-bit form |
| req_pos | input | 3 | Bit position for the single-bit form |
| req_level | input | 1 | Level written by the single-bit form |
| req_value | input | 8 | New bit values for the masked form |
| req_mask | input | 8 | Bits to change for the masked form |
| busy | output | 1 | Transfer in flight |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err | output | 1 | One-cycle pulse for a refused latch number |
| bus_data | output | 8 | Shared latch data bus |
| strobe_n | output | 4 | Active-low load lines, one per latch |
| shadow_flat | output | 32 | Stored copies, latch n in bits 8n+7:8n |

## Verification
The bench targets the following failure modes:
- Wrong merge polarity, which would leak unmasked bits of the new value or clear kept bits in the stored copy.
- Phase lengths that are off by one cycle.
- A load line that drops early, before the data phase has run its full length.
- A done pulse that overlaps busy or lasts two cycles.
- Requests sent while busy, which a faulty design would let corrupt the bus byte.
- Out-of-range latch numbers, which a faulty design might fold onto latch 0..3.
- Single-bit requests at bit positions 0 and 7.

// File: rtl/lbw_pkg.sv
package lbw_pkg;
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_DATA    = 2'd1,
        PH_STROBE  = 2'd2,
        PH_RELEASE = 2'd3
    } phase_e;
endpackage

// File: rtl/lbw_settle.sv
module lbw_settle #(
    parameter int DELAY_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int CW = $clog2(DELAY_CYC + 1);
    localparam logic [CW-1:0] RELOAD = CW'(DELAY_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = RELOAD;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/lbw_merge.sv
module lbw_merge #(
    parameter int DW = 8
) (
    input  logic [DW-1:0]         old_val,
    input  logic                  bit_mode,
    input  logic [$clog2(DW)-1:0] bit_pos,
    input  logic                  bit_level,
    input  logic [DW-1:0]         value,
    input  logic [DW-1:0]         mask,
    output logic [DW-1:0]         merged
);
    logic [DW-1:0] eff_mask, eff_val;

    always_comb begin
        if (bit_mode) begin
            eff_mask = {{(DW-1){1'b0}}, 1'b1} << bit_pos;
            eff_val  = bit_level ? eff_mask : '0;
        end else begin
            eff_mask = mask;
            eff_val  = value;
        end
        merged = (old_val & ~eff_mask) | (eff_val & eff_mask);
    end
endmodule

// File: rtl/lbw_strobe_dec.sv
module lbw_strobe_dec #(
    parameter int NUM_LATCH = 4
) (
    input  logic                         active,
    input  logic [$clog2(NUM_LATCH)-1:0] sel,
    output logic [NUM_LATCH-1:0]         strobe_n
);
    for (genvar i = 0; i < NUM_LATCH; i++) begin : g_line
        assign strobe_n[i] = !(active && (sel == i));
    end
endmodule

// File: rtl/latch_bus_writer.sv
module latch_bus_writer #(
    parameter int NUM_LATCH = 4,
    parameter int DW        = 8,
    parameter int IDX_W     = 3,
    parameter int DELAY_CYC = 50
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [IDX_W-1:0]        req_idx,
    input  logic                    req_bit,
    input  logic [$clog2(DW)-1:0]   req_pos,
    input  logic                    req_level,
    input  logic [DW-1:0]           req_value,
    input  logic [DW-1:0]           req_mask,
    output logic                    busy,
    output logic                    done,
    output logic                    err,
    output logic [DW-1:0]           bus_data,
    output logic [NUM_LATCH-1:0]    strobe_n,
    output logic [NUM_LATCH*DW-1:0] shadow_flat
);
    import lbw_pkg::*;

    localparam int SEL_W = $clog2(NUM_LATCH);

    typedef struct packed {
        phase_e                      phase;
        logic [SEL_W-1:0]            sel;
        logic [DW-1:0]               bus;
        logic [NUM_LATCH-1:0][DW-1:0] shadow;
        logic                        done;
        logic                        err;
    } state_t;

    state_t st_d, st_q;
    logic   tmr_load, tmr_expired;
    logic   idx_ok;
    logic [SEL_W-1:0] idx_sel;
    logic [DW-1:0]    merged;

    assign idx_ok  = (req_idx < IDX_W'(NUM_LATCH));
    assign idx_sel = req_idx[SEL_W-1:0];

    lbw_merge #(.DW(DW)) i_merge (
        .old_val  (st_q.shadow[idx_sel]),
        .bit_mode (req_bit),
        .bit_pos  (req_pos),
        .bit_level(req_level),
        .value    (req_value),
        .mask     (req_mask),
        .merged   (merged)
    );

    lbw_settle #(.DELAY_CYC(DELAY_CYC)) i_settle (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tmr_load),
        .expired(tmr_expired)
    );

    lbw_strobe_dec #(.NUM_LATCH(NUM_LATCH)) i_dec (
        .active  (st_q.phase == PH_STROBE),
        .sel     (st_q.sel),
        .strobe_n(strobe_n)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.err  = 1'b0;
        tmr_load  = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    if (idx_ok) begin
                        st_d.shadow[idx_sel] = merged;
                        st_d.bus             = merged;
                        st_d.sel             = idx_sel;
                        st_d.phase           = PH_DATA;
                        tmr_load             = 1'b1;
                    end else begin
                        st_d.err = 1'b1;
                    end
                end
            end
            PH_DATA: begin
                if (tmr_expired) begin
                    st_d.phase = PH_STROBE;
                    tmr_load   = 1'b1;
                end
            end
            PH_STROBE: begin
                if (tmr_expired) begin
                    st_d.phase = PH_RELEASE;
                    tmr_load   = 1'b1;
                end
            end
            default: begin
                if (tmr_expired) begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, sel: '0, bus: '0, shadow: '0,
                      done: 1'b0, err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy        = (st_q.phase != PH_IDLE);
    assign done        = st_q.done;
    assign err         = st_q.err;
    assign bus_data    = st_q.bus;
    assign shadow_flat = st_q.shadow;
endmodule

// File: rtl/lbw_checker.sv
module lbw_checker #(
    parameter int NUM_LATCH = 4,
    parameter int DW        = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    busy,
    input logic                    done,
    input logic                    err,
    input logic [DW-1:0]           bus_data,
    input logic [NUM_LATCH-1:0]    strobe_n,
    input logic [NUM_LATCH*DW-1:0] shadow_flat
);
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~strobe_n) <= 1); // R4
    AST_STROBE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_n != '1) |-> busy); // R5
    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $fell(busy))); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_BUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(bus_data)); // R3
    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && $stable(shadow_flat))); // R8
    for (genvar n = 0; n < NUM_LATCH; n++) begin : g_match
        AST_BUS_EQ_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
            !strobe_n[n] |-> (bus_data == shadow_flat[n*DW +: DW])); // R3
    end
endmodule

bind latch_bus_writer lbw_checker #(.NUM_LATCH(NUM_LATCH), .DW(DW)) i_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
    .bus_data(bus_data), .strobe_n(strobe_n), .shadow_flat(shadow_flat)
);

// File: tb/test_latch_bus_writer.sv
module test_latch_bus_writer;
    localparam int D = 3;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        req_valid = 0;
    logic [2:0]  req_idx = 0;
    logic        req_bit = 0;
    logic [2:0]  req_pos = 0;
    logic        req_level = 0;
    logic [7:0]  req_value = 0;
    logic [7:0]  req_mask = 0;
    logic        busy, done, err;
    logic [7:0]  bus_data;
    logic [3:0]  strobe_n;
    logic [31:0] shadow_flat;

    int checks = 0;
    int errors = 0;
    logic [7:0] mdl [4];
    logic [7:0] mdl_bus;

    always #2 clk = ~clk;

    latch_bus_writer #(.DELAY_CYC(D)) i_latch_bus_writer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_idx(req_idx),
        .req_bit(req_bit), .req_pos(req_pos), .req_level(req_level),
        .req_value(req_value), .req_mask(req_mask), .busy(busy), .done(done),
        .err(err), .bus_data(bus_data), .strobe_n(strobe_n),
        .shadow_flat(shadow_flat)
    );

    function automatic logic [7:0] f_merge(input logic [7:0] o, v, m);
        return (o & ~m) | (v & m);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_shadows(input string req);
        for (int n = 0; n < 4; n++)
            chk(req, {24'd0, shadow_flat[n*8 +: 8]}, {24'd0, mdl[n]});
    endtask

    // Drives one request at a negedge and follows it to the end.
    // intrude: present a second request in the middle of the transfer.
    task automatic run_req(input logic [2:0] idx, input logic bm,
                           input logic [2:0] pos, input logic lvl,
                           input logic [7:0] v, input logic [7:0] m,
                           input logic intrude);
        logic [7:0] em, ev;
        logic [3:0] exp_strobe;
        req_valid = 1; req_idx = idx; req_bit = bm; req_pos = pos;
        req_level = lvl; req_value = v; req_mask = m;
        @(posedge clk); @(negedge clk);
        req_valid = 0;
        if (idx >= 4) begin
            chk("R8 err pulse", {31'd0, err}, 32'd1);
            chk("R8 no busy", {31'd0, busy}, 32'd0);
            chk("R8 bus kept", {24'd0, bus_data}, {24'd0, mdl_bus});
            chk("R8 strobe idle", {28'd0, strobe_n}, 32'hF);
            chk_shadows("R8 shadows kept");
            @(negedge clk);
            chk("R8 err one cycle", {31'd0, err}, 32'd0);
            return;
        end
        if (bm) begin
            em = 8'd1 << pos; ev = lvl ? em : 8'd0;   // R9
        end else begin
            em = m; ev = v;
        end
        mdl[idx[1:0]] = f_merge(mdl[idx[1:0]], ev, em);
        mdl_bus = mdl[idx[1:0]];
        exp_strobe = 4'hF ^ (4'd1 << idx[1:0]);
        // k = 1
        chk_shadows(bm ? "R9 bit write" : "R2/R10 merge");
        chk("R3 bus byte", {24'd0, bus_data}, {24'd0, mdl_bus});
        chk("R5 data phase strobe idle", {28'd0, strobe_n}, 32'hF);
        chk("R6 busy up", {31'd0, busy}, 32'd1);
        for (int k = 2; k <= 3*D + 2; k++) begin
            if (intrude && k == 2) begin
                req_valid = 1; req_idx = idx ^ 3'd1; req_bit = 0;
                req_value = ~mdl[idx[1:0] ^ 2'd1]; req_mask = 8'hFF;
            end
            @(negedge clk);
            req_valid = 0;
            if (k == D)         chk("R5 strobe not early", {28'd0, strobe_n}, 32'hF);
            if (k == D + 1)     chk("R4 strobe select", {28'd0, strobe_n}, {28'd0, exp_strobe});
            if (k == 2*D)       chk("R5 strobe width", {28'd0, strobe_n}, {28'd0, exp_strobe});
            if (k == 2*D + 1)   chk("R5 strobe release", {28'd0, strobe_n}, 32'hF);
            if (k == 3*D)       chk("R6 busy length", {30'd0, busy, done}, 32'd2);
            if (k == 3*D + 1)   chk("R6 done pulse", {30'd0, busy, done}, 32'd1);
            if (k == 3*D + 2)   chk("R6 done one cycle", {31'd0, done}, 32'd0);
        end
        if (intrude) begin
            chk_shadows("R7 ignored while busy");
            chk("R7 bus kept", {24'd0, bus_data}, {24'd0, mdl_bus});
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int n = 0; n < 4; n++) mdl[n] = 8'h00;
        mdl_bus = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk_shadows("R1 reset shadows");
        chk("R1 reset bus", {24'd0, bus_data}, 32'd0);
        chk("R1 reset strobe", {28'd0, strobe_n}, 32'hF);
        chk("R1 reset flags", {29'd0, busy, done, err}, 32'd0);

        run_req(3'd0, 0, 0, 0, 8'hFF, 8'hFF, 0);  // all ones
        run_req(3'd0, 0, 0, 0, 8'h00, 8'h0F, 0);  // partial clear
        run_req(3'd1, 0, 0, 0, 8'hA5, 8'h00, 0);  // zero mask
        run_req(3'd3, 0, 0, 0, 8'h5A, 8'hF0, 1);  // with intruding request
        run_req(3'd2, 1, 3'd7, 1, 8'h00, 8'h00, 0); // R9 top bit set
        run_req(3'd2, 1, 3'd0, 1, 8'h00, 8'h00, 0); // R9 bottom bit set
        run_req(3'd2, 1, 3'd7, 0, 8'hFF, 8'hFF, 0); // R9 clear, ignores value/mask
        run_req(3'd4, 0, 0, 0, 8'hFF, 8'hFF, 0);  // R8
        run_req(3'd7, 1, 3'd2, 1, 8'hFF, 8'hFF, 0); // R8

        for (int i = 0; i < 40; i++) begin
            run_req(3'($urandom_range(0, 4)), 1'($urandom), 3'($urandom),
                    1'($urandom), 8'($urandom), 8'($urandom),
                    1'($urandom_range(0, 3) == 0));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule